// File: doc/BRIEF.md
# Multiplexed Bus Memory Target

This block is a memory-style slave on a 32-bit bus that carries both address and data on the same lines. It takes four active-low control strobes and a 4-bit command/byte-enable field. When the master begins a transaction, the block reads the address and the command. It claims the access when the command is memory read or memory write and the address lies inside its window. It then runs one or more data phases against a small internal word store. Writes are masked per byte lane. Reads return the stored word.

Data phases advance one word at a time for as long as the master holds the frame strobe low. Either side can insert wait cycles. If a burst would run past the last word of the window, the block disconnects.

The controller is a single state machine with these states:
- **IDLE**: waiting for a transaction to start.
- **ADEC**: the decode cycle after a claimed address phase.
- **RWAIT**: the fixed read wait state.
- **XFER**: data phases in progress.
- **DISC**: requesting a stop.
- **BUSY**: tracking a transaction that belongs to another agent.

Its transitions are:
- IDLE→ADEC on a claimed start, and IDLE→BUSY on an unclaimed one.
- ADEC→RWAIT for reads, and ADEC→XFER for writes.
- RWAIT→XFER always.
- XFER→XFER on a completed phase that is neither the last nor at the window end, or on a wait cycle.
- XFER→IDLE when the final phase completes.
- XFER→DISC when a phase on the last window word completes while frame is still low.
- DISC→IDLE once frame is sampled high.
- BUSY→IDLE once frame and irdy are both sampled high.

Top module: `mbus_target`

## Requirements
- R1: While reset is low and after it is released, devsel_n, trdy_n and stop_n are 1 and ad_oe is 0. Every stored word reads back as zero before its first write.
- R2: Only command 4'b0110 (memory read) and command 4'b0111 (memory write) are claimed, and only when address bits [31:5] equal those of BASE_ADDR. For any other command or address, devsel_n and trdy_n stay 1 for the whole transaction.
- R3: Let the address phase be the rising edge at which frame_n is first sampled 0 in IDLE. devsel_n is 1 at the next edge and is sampled 0 at the second edge after the address phase.
- R4: For a write, trdy_n is sampled 0 at the same edge as the first 0 of devsel_n. For a read, trdy_n stays 1 at that edge and is sampled 0 one edge later, with ad_oe already 1.
- R5: A data phase completes only at an edge where irdy_n and trdy_n are both 0. A cycle where the master holds irdy_n at 1 transfers and stores nothing.
- R6: On a write, cbe_n bit i = 0 stores ad_in[8i+7:8i]. Lanes whose bit is 1 keep their old contents.
- R7: Address bits [4:2] select the first word. Each completed data phase advances to the next word, that is 4 bytes higher.
- R8: A phase that completes with frame_n sampled 1 is the last one. At the following edge devsel_n, trdy_n and stop_n are all 1 and ad_oe is 0.
- R9: If a phase on word 7 completes while frame_n is still 0, the next edge shows stop_n 0, trdy_n 1 and devsel_n 0. No further data is transferred. All three are released at the edge after frame_n is sampled 1.
- R10: During a read phase with trdy_n 0, ad_out holds the stored word at the current burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Address/data lines as driven by the master |
| ad_out | output | 32 | Read data driven by the target |
| ad_oe | output | 1 | High while the target drives ad_out |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frame_n | input | 1 | Active-low transaction frame from the master |
| irdy_n | input | 1 | Active-low master ready |
| trdy_n | output | 1 | Active-low target ready |
| devsel_n | output | 1 | Active-low claim of the current access |
| stop_n | output | 1 | Active-low request that the master end the transaction |

## Verification
A corrupted burst word index shows up at the ports on the very next read phase, because ad_out carries the wrong stored word. On writes it appears as misplaced lanes in a later read-back. A state machine stuck in or skipping a state is visible within one or two edges as a devsel_n, trdy_n or stop_n level that breaks the fixed decode and wait timing. The bench sweeps every start word, every command code and master wait counts of 0 and 1, and walks bursts across the window end. Expected values come from an arithmetic model of the word store.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADEC,
        ST_RWAIT,
        ST_XFER,
        ST_DISC,
        ST_BUSY
    } mbt_state_e;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam int         LANES      = 4;
endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
    import mbt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0000_4000,
    parameter int          IDX_W     = 3
) (
    input  logic [31:0]      addr,
    input  logic [3:0]       cmd,
    output logic             hit,
    output logic             is_read,
    output logic [IDX_W-1:0] word
);
    localparam int WIN_BITS = IDX_W + 2;

    logic cmd_ok;
    logic win_ok;

    always_comb begin
        cmd_ok  = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
        win_ok  = (addr[31:WIN_BITS] == BASE_ADDR[31:WIN_BITS]);
        hit     = cmd_ok && win_ok;
        is_read = (cmd == CMD_MEM_RD);
        word    = addr[WIN_BITS-1:2];
    end
endmodule

// File: rtl/mbt_regfile.sv
module mbt_regfile
    import mbt_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    input  logic [3:0]       wbe_n,
    output logic [31:0]      rdata
);
    logic [31:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [31:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                for (int b = 0; b < LANES; b++) begin
                    if (!wbe_n[b]) word_q[8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
        assign words[g] = word_q;
    end

    assign rdata = words[idx];
endmodule

// File: rtl/mbt_fsm.sv
module mbt_fsm
    import mbt_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             dec_hit,
    input  logic             dec_read,
    input  logic [IDX_W-1:0] dec_word,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n,
    output logic             ad_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] word_idx
);
    localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(WORDS - 1);

    mbt_state_e       state_q, state_d;
    logic             rd_q;
    logic [IDX_W-1:0] idx_q;
    logic             phase_done;

    assign phase_done = (state_q == ST_XFER) && !irdy_n && !trdy_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!frame_n) state_d = dec_hit ? ST_ADEC : ST_BUSY;
            ST_ADEC:  state_d = rd_q ? ST_RWAIT : ST_XFER;
            ST_RWAIT: state_d = ST_XFER;
            ST_XFER: begin
                if (phase_done) begin
                    if (frame_n)                 state_d = ST_IDLE;
                    else if (idx_q == LAST_WORD) state_d = ST_DISC;
                end
            end
            ST_DISC:  if (frame_n) state_d = ST_IDLE;
            ST_BUSY:  if (frame_n && irdy_n) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= 1'b0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && !frame_n && dec_hit) begin
                rd_q  <= dec_read;
                idx_q <= dec_word;
            end else if (phase_done) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
            ad_oe    <= 1'b0;
        end else begin
            devsel_n <= !(state_d inside {ST_RWAIT, ST_XFER, ST_DISC});
            trdy_n   <= (state_d != ST_XFER);
            stop_n   <= (state_d != ST_DISC);
            ad_oe    <= rd_q && (state_d inside {ST_RWAIT, ST_XFER});
        end
    end

    assign wr_en    = phase_done && !rd_q;
    assign word_idx = idx_q;

    // R3
    devsel_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> ($past(frame_n, 2) == 1'b0));

    // R4
    rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(trdy_n) && rd_q) |-> ($past(devsel_n) == 1'b0));

    // R2
    trdy_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    // R9
    stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> (trdy_n && !devsel_n));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (trdy_n && devsel_n && stop_n && !ad_oe));
endmodule

// File: rtl/mbus_target.sv
module mbus_target
    import mbt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h0000_4000,
    parameter int          WORDS     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    input  logic [3:0]  cbe_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    output logic        trdy_n,
    output logic        devsel_n,
    output logic        stop_n
);
    localparam int IDX_W = $clog2(WORDS);

    logic             hit, is_read, wr_en;
    logic [IDX_W-1:0] dec_word, word_idx;
    logic [31:0]      rdata;

    mbt_decode #(.BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) u_dec (
        .addr(ad_in), .cmd(cbe_n), .hit(hit), .is_read(is_read), .word(dec_word)
    );

    mbt_fsm #(.WORDS(WORDS), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .dec_hit(hit), .dec_read(is_read), .dec_word(dec_word),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .ad_oe(ad_oe),
        .wr_en(wr_en), .word_idx(word_idx)
    );

    mbt_regfile #(.WORDS(WORDS), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .idx(word_idx),
        .wdata(ad_in), .wbe_n(cbe_n), .rdata(rdata)
    );

    assign ad_out = ad_oe ? rdata : '0;
endmodule

// File: tb/mbus_target_tb_top.sv
module mbus_target_tb_top;
    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam int          NW   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic [3:0]  cbe_n = 4'hF;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        trdy_n, devsel_n, stop_n;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [31:0] mem   [NW];
    logic [31:0] wdat  [16];
    logic [3:0]  wbe   [16];

    always #2 clk = ~clk;

    mbus_target #(.BASE_ADDR(BASE), .WORDS(NW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .devsel_n(devsel_n), .stop_n(stop_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_released(input string tag);
        chk(devsel_n && trdy_n && stop_n && !ad_oe, tag,
            {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'h0000_000E);
    endtask

    // One transaction; returns number of completed data phases.
    task automatic xact(input logic [31:0] addr, input logic [3:0] cmd,
                        input int nph, input int mw, output int done);
        bit hit, rd, comp, last;
        int idx, ph, w, j;
        done = 0;
        hit = ((cmd == 4'b0110) || (cmd == 4'b0111)) && (addr[31:5] == BASE[31:5]);
        rd  = (cmd == 4'b0110);
        idx = int'(addr[4:2]);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd;
        @(posedge clk);
        @(negedge clk);
        if (!hit) begin
            irdy_n = 1'b0; ad_in = '0; cbe_n = 4'h0;
            for (int k = 0; k < 4; k++) begin
                // R2: unclaimed access never selected
                chk(devsel_n && trdy_n, "R2 unclaimed", {30'd0, devsel_n, trdy_n}, 32'h3);
                @(negedge clk);
            end
            frame_n = 1'b1;
            @(negedge clk);
            irdy_n = 1'b1;
            @(negedge clk);
            chk_released("R2 after unclaimed");
            return;
        end
        ph = 0; w = mw; j = 0;
        forever begin
            if (j == 0) chk(devsel_n && trdy_n, "R3 devsel early", {30'd0, devsel_n, trdy_n}, 32'h3);
            if (j == 1) begin
                chk(!devsel_n, "R3 devsel timing", {31'd0, devsel_n}, 32'h0);
                chk(trdy_n == rd, "R4 first trdy", {31'd0, trdy_n}, {31'd0, rd});
                if (rd) chk(ad_oe, "R4 read oe", {31'd0, ad_oe}, 32'h1);
            end
            if (j == 2 && rd) chk(!trdy_n, "R4 read trdy", {31'd0, trdy_n}, 32'h0);
            if (w > 0) begin irdy_n = 1'b1; w--; end
            else irdy_n = 1'b0;
            frame_n = (ph == nph - 1 && !irdy_n) ? 1'b1 : 1'b0;
            ad_in = rd ? 32'h0 : wdat[ph];
            cbe_n = wbe[ph];
            comp = !irdy_n && !trdy_n;
            if (comp && rd)
                // R10 R7: read data at current burst word
                chk(ad_out == mem[idx] && ad_oe, "R10 read data", ad_out, mem[idx]);
            @(posedge clk);
            if (comp) begin
                if (!rd)
                    for (int b = 0; b < 4; b++)
                        if (!wbe[ph][b]) mem[idx][8*b +: 8] = wdat[ph][8*b +: 8]; // R6
                last = frame_n;
                ph++; done++; w = mw;
                if (last) begin
                    @(negedge clk);
                    chk_released("R8 release");
                    irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
                    return;
                end
                if (idx == NW - 1) begin
                    @(negedge clk);
                    // R9 disconnect
                    chk(!stop_n && trdy_n && !devsel_n, "R9 stop",
                        {29'd0, stop_n, trdy_n, devsel_n}, 32'h2);
                    frame_n = 1'b1; irdy_n = 1'b0;
                    @(posedge clk);
                    @(negedge clk);
                    chk_released("R9 release");
                    irdy_n = 1'b1; ad_in = '0; cbe_n = 4'hF;
                    return;
                end
                idx++;
            end
            @(negedge clk);
            j++;
        end
    endtask

    task automatic read_all(input int mw, input string tag);
        int d;
        xact(BASE, 4'b0110, NW, mw, d);
        chk(d == NW, tag, d, NW);
    endtask

    initial begin
        int d;
        for (int i = 0; i < NW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_released("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_released("R1 after reset");
        read_all(0, "R1 zero readback");

        // R2: every command code inside the window
        for (int c = 0; c < 16; c++) begin
            xact(BASE + 32'd8, 4'(c), 1, 0, d);
            if (c == 6 || c == 7) chk(d == 1, "R2 claimed cmd", d, 1);
        end
        // R2: outside the window
        xact(BASE + 32'd32, 4'b0111, 1, 0, d);
        xact(BASE - 32'd4, 4'b0110, 1, 0, d);
        xact(BASE ^ 32'h8000_0000, 4'b0111, 1, 0, d);
        read_all(0, "R2 store untouched");

        // R5 R6 R7: bursts from each start word, master waits 0 and 1
        for (int mw = 0; mw < 2; mw++) begin
            for (int s = 0; s < NW; s++) begin
                for (int p = 0; p < 16; p++) begin
                    wdat[p] = 32'h1357_9BDF * (p + 1) + 32'(s * 77 + mw * 1000);
                    wbe[p]  = 4'(p + s + mw * 5);
                end
                xact(BASE + 32'(4 * s) + 32'(s & 3), 4'b0111, NW - s, mw, d);
                chk(d == NW - s, "R7 write burst length", d, NW - s);
                read_all((s + mw) % 3, "R5 burst readback");
            end
        end

        // R9: write burst running past the window end
        for (int p = 0; p < 16; p++) begin wdat[p] = 32'hC0DE_0000 + 32'(p); wbe[p] = 4'h0; end
        xact(BASE + 32'd20, 4'b0111, 6, 0, d);
        chk(d == 3, "R9 write disconnect count", d, 3);
        read_all(1, "R9 no overrun");
        xact(BASE + 32'd24, 4'b0110, 4, 1, d);
        chk(d == 2, "R9 read disconnect count", d, 2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule